// File: doc/BRIEF.md
# Data-Object Mailbox Responder with Discovery

This block is the device side of a data-object mailbox capability. Its register file sits behind a 32-bit configuration-style port with byte addresses and single-cycle writes; reads are combinational and have no side effects. Software writes a request object one dword at a time into a write mailbox and then sets GO. The block checks the request and builds a response object. Software reads the response through a read mailbox, one dword at a time.

Only the discovery protocol (object type 0) is answered. It is served from a table that a parameter sets. Entry 0 is always discovery itself, under a vendor ID that a parameter also sets. Each response names one supported vendor-ID/type pair and the index of the next entry; a next index of 0 ends the chain. A malformed or unsupported request sets the error flag. Abort flushes both mailboxes and returns the block to idle in one cycle. When interrupts are enabled, a finished response sets a write-1-to-clear interrupt status bit and raises a one-cycle pulse.

Register offsets:

| Offset | Contents |
|--------|----------|
| 0x00 | Extended capability header |
| 0x04 | Capability |
| 0x08 | Control |
| 0x0C | Status |
| 0x10 | Write mailbox |
| 0x14 | Read mailbox |

Top module: `mbx_responder`

## Requirements
- R1: Header, capability and reset state.
  - After reset, control (0x08) and status (0x0C) read 0.
  - Offset 0x00 reads 0x0001_002E: ID 0x2E in bits 15:0 and version 1 in bits 19:16.
  - Capability (0x04) reads interrupt support in bit 0 and the message number in bits 11:1.
- R2: Discovery response to index 0.
  - A request of exactly three dwords is accepted.
  - Dword 1 holds vendor ID 0x0001 in bits 15:0 and type 0 in bits 23:16.
  - Dword 2 holds length 3 in bits 17:0.
  - Dword 3 holds the index in bits 7:0.
  - The response is three dwords: the same header, length 3, then {next index[31:24], type[23:16], vendor ID[15:0]} of entry 0, with next index 1.
- R3: Every table index returns its own entry. The last entry reports next index 0.
- R4: Reading the read mailbox (0x14) returns the current response dword and does not move it. A write of any value to 0x14 advances to the next dword. Data-object-ready (status bit 31) drops after the third advance, and 0x14 then reads 0.
- R5: Accepting GO (control bit 31) sets busy (status bit 0) for exactly one cycle. In the next cycle busy clears and the response is ready.
- R6: These requests set error (status bit 2) and produce no response:
  - an index at or beyond the table size;
  - a length field other than 3;
  - a wrong vendor ID or a type other than 0;
  - nonzero reserved bits;
  - a dword count other than three.
- R7: While error is set, GO is ignored.
- R8: Abort (control bit 0) takes priority over GO. Within one cycle it clears busy, error and data-object-ready and empties the write mailbox.
- R9: Interrupts.
  - With interrupt enable (control bit 1) set, a completed response sets interrupt status (status bit 1) and pulses `irqPulse` for one cycle.
  - Writing 1 to status bit 1 clears interrupt status.
  - With enable clear, there is no pulse and no status.
- R10: Dwords written beyond the write-mailbox depth are dropped. A later GO then sets error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | 8 | Byte address of the register |
| cfgWrEn | input | 1 | Write strobe, one cycle per write |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Combinational read data for cfgAddr |
| irqPulse | output | 1 | One-cycle pulse when a response becomes ready with interrupts enabled |

## Verification
The bench walks the whole discovery chain and checks that the last index returns next index 0. A design with an off-by-one in the chain would loop forever or stop early.

It reads the read mailbox twice between advances, to catch a design that advances on reads. It counts exactly three advances before ready drops, to catch one that ends the object early or late.

Several requests are made invalid in different ways: out-of-range index, bad length, short object and overflowed object. Each must raise error. A GO sent while error is set must leave everything unchanged.

Abort is sent after a partial request. A design that did not flush the write mailbox would then reject the next well-formed request.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] OFF_HDR = 8'h00;
  localparam logic [7:0] OFF_CAP = 8'h04;
  localparam logic [7:0] OFF_CTL = 8'h08;
  localparam logic [7:0] OFF_STS = 8'h0C;
  localparam logic [7:0] OFF_WMB = 8'h10;
  localparam logic [7:0] OFF_RMB = 8'h14;
  localparam logic [15:0] EXT_CAP_ID = 16'h002E;
  localparam logic [3:0]  CAP_VER    = 4'h1;
  localparam int RSP_WORDS = 3;

  typedef struct packed {
    logic flush;     // empty the write mailbox
    logic load;      // capture a response object
    logic advance;   // step the read mailbox
    logic clearRsp;  // rewind the read mailbox
  } mbxStrobe_t;

  typedef enum logic {ST_IDLE, ST_EVAL} mbxState_t;
endpackage

// File: rtl/mbx_data.sv
module mbx_data
  import mbx_pkg::*;
#(
  parameter int          WR_DEPTH   = 8,
  parameter logic [15:0] DISC_VID   = 16'h0001,
  parameter int          NUM_EXTRA  = 2,
  parameter logic [NUM_EXTRA*24-1:0] EXTRA_LIST = 48'h07ABCD_011234
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrPush,
  input  logic [31:0] wrData,
  input  mbxStrobe_t  strobe,
  output logic        reqOk,
  output logic        rdLast,
  output logic [31:0] rspWord
);
  localparam int NUM_PROTOS = NUM_EXTRA + 1;
  localparam int CNT_W = $clog2(WR_DEPTH + 1);
  localparam int PTR_W = (WR_DEPTH > 1) ? $clog2(WR_DEPTH) : 1;

  logic [31:0] fifoMem [WR_DEPTH];
  logic [CNT_W-1:0] wrCount;
  logic wrOvf;
  logic [23:0] protoTab [NUM_PROTOS];
  logic [31:0] rspMem [RSP_WORDS];
  logic [1:0]  rdPtr;

  // discovery table, entry 0 is discovery itself
  assign protoTab[0] = {8'h00, DISC_VID};
  for (genvar gi = 1; gi < NUM_PROTOS; gi++) begin : g_tab
    assign protoTab[gi] = EXTRA_LIST[(gi-1)*24 +: 24];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrCount <= '0;
      wrOvf   <= 1'b0;
    end else if (wrPush) begin
      if (wrCount == CNT_W'(WR_DEPTH)) wrOvf <= 1'b1;
      else wrCount <= wrCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrPush && wrCount != CNT_W'(WR_DEPTH))
      fifoMem[wrCount[PTR_W-1:0]] <= wrData;
  end

  logic [31:0] hdrA, hdrB, reqDw;
  logic [7:0]  reqIdx, nextIdx;
  logic [23:0] selEntry;
  assign hdrA   = fifoMem[0];
  assign hdrB   = fifoMem[1];
  assign reqDw  = fifoMem[2];
  assign reqIdx = reqDw[7:0];

  always_comb begin
    selEntry = '0;
    for (int i = 0; i < NUM_PROTOS; i++)
      if (reqIdx == 8'(i)) selEntry = protoTab[i];
    nextIdx = (reqIdx == 8'(NUM_PROTOS - 1)) ? 8'd0 : reqIdx + 8'd1;
  end

  assign reqOk = !wrOvf && wrCount == CNT_W'(3)
              && hdrA == {16'h0000, DISC_VID}
              && hdrB == 32'd3
              && reqDw[31:8] == 24'd0
              && reqIdx < 8'(NUM_PROTOS);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearRsp) begin
      rdPtr <= '0;
    end else if (strobe.load) begin
      rspMem[0] <= {16'h0000, DISC_VID};
      rspMem[1] <= 32'd3;
      rspMem[2] <= {nextIdx, selEntry};
      rdPtr     <= '0;
    end else if (strobe.advance) begin
      rdPtr <= rdPtr + 2'd1;
    end
  end

  assign rdLast  = rdPtr == 2'(RSP_WORDS - 1);
  assign rspWord = (rdPtr < 2'(RSP_WORDS)) ? rspMem[rdPtr] : 32'd0;

  // R10
  wr_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCount <= CNT_W'(WR_DEPTH));
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (wrCount == '0 && !wrOvf));
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       goReq,
  input  logic       abortReq,
  input  logic       intEnWr,
  input  logic       intEnVal,
  input  logic       intClr,
  input  logic       rdAdvReq,
  input  logic       reqOk,
  input  logic       rdLast,
  output logic       busy,
  output logic       error,
  output logic       ready,
  output logic       intEn,
  output logic       intSts,
  output logic       irq,
  output mbxStrobe_t strobe
);
  mbxState_t state;
  logic goAccept, finishOk;

  assign goAccept = goReq && !abortReq && state == ST_IDLE && !error;
  assign finishOk = state == ST_EVAL && !abortReq && reqOk;

  always_comb begin
    strobe.flush    = abortReq || state == ST_EVAL;
    strobe.load     = finishOk;
    strobe.advance  = rdAdvReq && ready && !abortReq;
    strobe.clearRsp = abortReq || goAccept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      busy <= 1'b0; error <= 1'b0; ready <= 1'b0;
      intEn <= 1'b0; intSts <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (intEnWr) intEn <= intEnVal;
      if (intClr) intSts <= 1'b0;
      if (abortReq) begin
        state <= ST_IDLE;
        busy <= 1'b0; error <= 1'b0; ready <= 1'b0;
      end else if (state == ST_EVAL) begin
        state <= ST_IDLE;
        busy  <= 1'b0;
        if (reqOk) begin
          ready <= 1'b1;
          if (intEn) begin
            intSts <= 1'b1;
            irq    <= 1'b1;
          end
        end else begin
          error <= 1'b1;
        end
      end else if (goAccept) begin
        state <= ST_EVAL;
        busy  <= 1'b1;
        ready <= 1'b0;
      end else if (strobe.advance && rdLast) begin
        ready <= 1'b0;
      end
    end
  end

  // R5
  busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && ready));
  // R5
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R8
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (!busy && !error && !ready));
  // R9
  irq_sets_sts_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (intSts && ready));
  // R7
  err_blocks_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    (error && !abortReq) |=> !busy);
endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
  import mbx_pkg::*;
#(
  parameter int          WR_DEPTH    = 8,
  parameter logic [15:0] DISC_VID    = 16'h0001,
  parameter int          NUM_EXTRA   = 2,
  parameter logic [NUM_EXTRA*24-1:0] EXTRA_LIST = 48'h07ABCD_011234,
  parameter logic        INT_SUPPORT = 1'b1,
  parameter logic [10:0] IRQ_MSG_NUM = 11'd5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  cfgAddr,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  output logic        irqPulse
);
  mbxStrobe_t strobe;
  logic busy, error, ready, intEn, intSts, reqOk, rdLast;
  logic [31:0] rspWord;
  logic wrCtl;

  assign wrCtl = cfgWrEn && cfgAddr == OFF_CTL;

  mbx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .goReq(wrCtl && cfgWrData[31]),
    .abortReq(wrCtl && cfgWrData[0]),
    .intEnWr(wrCtl),
    .intEnVal(cfgWrData[1] & INT_SUPPORT),
    .intClr(cfgWrEn && cfgAddr == OFF_STS && cfgWrData[1]),
    .rdAdvReq(cfgWrEn && cfgAddr == OFF_RMB),
    .reqOk(reqOk), .rdLast(rdLast),
    .busy(busy), .error(error), .ready(ready),
    .intEn(intEn), .intSts(intSts), .irq(irqPulse),
    .strobe(strobe)
  );

  mbx_data #(
    .WR_DEPTH(WR_DEPTH), .DISC_VID(DISC_VID),
    .NUM_EXTRA(NUM_EXTRA), .EXTRA_LIST(EXTRA_LIST)
  ) u_data (
    .clk(clk), .rstN(rstN),
    .wrPush(cfgWrEn && cfgAddr == OFF_WMB && !busy),
    .wrData(cfgWrData),
    .strobe(strobe),
    .reqOk(reqOk), .rdLast(rdLast), .rspWord(rspWord)
  );

  always_comb begin
    unique case (cfgAddr)
      OFF_HDR: cfgRdData = {12'h000, CAP_VER, EXT_CAP_ID};
      OFF_CAP: cfgRdData = {20'h0, IRQ_MSG_NUM, INT_SUPPORT};
      OFF_CTL: cfgRdData = {30'h0, intEn, 1'b0};
      OFF_STS: cfgRdData = {ready, 28'h0, error, intSts, busy};
      OFF_RMB: cfgRdData = ready ? rspWord : 32'h0;
      default: cfgRdData = 32'h0;
    endcase
  end
endmodule

// File: tb/mbx_responder_tb.sv
module mbx_responder_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cfgAddr = 8'h0;
  logic cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = 32'h0;
  logic [31:0] cfgRdData;
  logic irqPulse;
  int nChecks = 0;
  int nFails = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  mbx_responder u_dut (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .irqPulse(irqPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdData;
  endtask

  task automatic sendDisc(input logic [7:0] idx, input logic [31:0] lenW);
    wr(8'h10, 32'h0000_0001);
    wr(8'h10, lenW);
    wr(8'h10, {24'h0, idx});
  endtask

  task automatic doAbort();
    wr(8'h08, 32'h0000_0001);
  endtask

  task automatic tReset();
    rd(8'h08, rv); chk("R1 ctrl", rv, 32'h0);
    rd(8'h0C, rv); chk("R1 status", rv, 32'h0);
    rd(8'h00, rv); chk("R1 header", rv, 32'h0001_002E);
    rd(8'h04, rv); chk("R1 cap", rv, {20'h0, 11'd5, 1'b1});
  endtask

  task automatic tBusyAndIdx0();
    sendDisc(8'd0, 32'd3);
    wr(8'h08, 32'h8000_0000);
    cfgAddr = 8'h0C;
    #1 chk("R5 busy after GO", cfgRdData, 32'h0000_0001);
    rd(8'h0C, rv); chk("R5 ready next cycle", rv, 32'h8000_0000);
    rd(8'h14, rv); chk("R2 rsp dw1", rv, 32'h0000_0001);
    rd(8'h14, rv); chk("R4 read does not advance", rv, 32'h0000_0001);
    wr(8'h14, 32'h0);
    rd(8'h14, rv); chk("R2 rsp dw2", rv, 32'd3);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, rv); chk("R2 rsp dw3", rv, 32'h0100_0001);
    rd(8'h0C, rv); chk("R4 ready before last advance", rv, 32'h8000_0000);
    wr(8'h14, 32'h0);
    rd(8'h0C, rv); chk("R4 ready drops", rv, 32'h0);
    rd(8'h14, rv); chk("R4 mailbox empty", rv, 32'h0);
  endtask

  task automatic discIdx(input logic [7:0] idx, input logic [31:0] expDw3);
    sendDisc(idx, 32'd3);
    wr(8'h08, 32'h8000_0000);
    @(negedge clk);
    wr(8'h14, 32'h0);
    wr(8'h14, 32'h0);
    rd(8'h14, rv); chk("R3 chain entry", rv, expDw3);
    wr(8'h14, 32'h0);
  endtask

  task automatic tChain();
    discIdx(8'd1, 32'h0201_1234);
    discIdx(8'd2, 32'h0007_ABCD);
  endtask

  task automatic expectErr(input string req);
    wr(8'h08, 32'h8000_0000);
    @(negedge clk);
    rd(8'h0C, rv); chk(req, rv, 32'h0000_0004);
    doAbort();
  endtask

  task automatic tErrors();
    sendDisc(8'd3, 32'd3); expectErr("R6 index out of range");
    sendDisc(8'd0, 32'd4); expectErr("R6 length mismatch");
    wr(8'h10, 32'h0000_0001); wr(8'h10, 32'd3); expectErr("R6 short object");
    wr(8'h10, 32'h0001_0001); wr(8'h10, 32'd3); wr(8'h10, 32'd0);
    expectErr("R6 unknown type");
  endtask

  task automatic tGoWhileErr();
    sendDisc(8'd9, 32'd3);
    wr(8'h08, 32'h8000_0000);
    @(negedge clk);
    sendDisc(8'd0, 32'd3);
    wr(8'h08, 32'h8000_0000);
    cfgAddr = 8'h0C;
    #1 chk("R7 GO ignored no busy", cfgRdData, 32'h0000_0004);
    rd(8'h0C, rv); chk("R7 still error no ready", rv, 32'h0000_0004);
    doAbort();
    rd(8'h0C, rv); chk("R8 abort clears error", rv, 32'h0);
  endtask

  task automatic tAbortFlush();
    wr(8'h10, 32'h0000_0001); wr(8'h10, 32'd3);
    doAbort();
    sendDisc(8'd0, 32'd3);
    wr(8'h08, 32'h8000_0000);
    @(negedge clk);
    rd(8'h0C, rv); chk("R8 flush lets next request pass", rv, 32'h8000_0000);
    wr(8'h08, 32'h8000_0001);
    rd(8'h0C, rv); chk("R8 abort wins over GO and clears ready", rv, 32'h0);
  endtask

  task automatic tIrq();
    sendDisc(8'd0, 32'd3);
    wr(8'h08, 32'h8000_0002);
    @(negedge clk);
    chk("R9 irq pulse", {31'h0, irqPulse}, 32'h1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'h0, irqPulse}, 32'h0);
    rd(8'h0C, rv); chk("R9 int status set", rv, 32'h8000_0002);
    wr(8'h0C, 32'h0000_0002);
    rd(8'h0C, rv); chk("R9 W1C clears", rv, 32'h8000_0000);
    rd(8'h08, rv); chk("R9 enable readable", rv, 32'h0000_0002);
    doAbort();
    sendDisc(8'd0, 32'd3);
    wr(8'h08, 32'h8000_0000);
    @(negedge clk);
    chk("R9 no pulse when disabled", {31'h0, irqPulse}, 32'h0);
    rd(8'h0C, rv); chk("R9 no status when disabled", rv, 32'h8000_0000);
    doAbort();
  endtask

  task automatic tOverflow();
    sendDisc(8'd0, 32'd3);
    for (int i = 0; i < 6; i++) wr(8'h10, 32'h0);
    expectErr("R10 overflow sets error");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBusyAndIdx0();
    tChain();
    tErrors();
    tGoWhileErr();
    tAbortFlush();
    tIrq();
    tOverflow();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule